// File: doc/BRIEF.md
# Debug Console UART

This block is a small asynchronous serial port meant for a chip's debug console. A transmitter and a receiver run independently of each other. Both take their timing from one shared rate generator. The generator produces an oversampling tick every `divisor` master clocks, so one bit lasts sixteen ticks. Characters always carry eight data bits, sent least significant bit first. They may carry a parity bit, and they end with one stop bit.

Software or a host block drives the rate divisor and the parity mode as plain levels. It hands transmit bytes over with a valid/ready handshake. It collects received bytes through a valid flag and a read strobe. Parity, framing and overrun problems are held in sticky flags, and a clear strobe empties them. A divisor of zero parks the whole port.

Top module: `dbg_uart`

## Requirements
- R1: One serial bit lasts 16 × `divisor` master clock cycles, for any divisor from 1 to 65535.
- R2: While `divisor` is 0, `txReady` is low, `txd` stays high, no transmit request is taken, and frames on `rxd` are not received.
- R3: A transmitted frame consists of a low start bit, then eight data bits least significant first, then an optional parity bit, then a high stop bit. `txd` rests high between frames.
- R4: `parMode` selects the parity bit: 0 = even (the bit makes the total count of ones even), 1 = odd, 2 = always 0, 3 = always 1, and 4 to 7 = no parity bit. The same encoding applies to transmit and to receive.
- R5: After a falling edge on `rxd`, the receiver checks the line again at the eighth tick. If the line is high at that point, it drops back to idle without delivering a byte.
- R6: A completed frame puts the byte on `rxData` and raises `rxValid`. A cycle with `rxRead` high lowers `rxValid`. If a frame completes in the same cycle as a read, `rxValid` stays high with the new byte.
- R7: A stop bit sampled low sets `frameErr`. All three error flags stay set until a cycle with `clrStatus` high, and clearing them leaves `rxData` and `rxValid` untouched.
- R8: When parity is enabled, a received parity bit that differs from the value expected for the mode sets `parityErr`.
- R9: If a frame completes while `rxValid` is still high and no read occurs in that cycle, `overrunErr` is set and `rxData` takes the new byte.
- R10: Any change of `divisor` restarts the divider count, so that bits which follow are timed at the new rate with no stall.
- R11: A transmission and a reception can run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low reset, synchronous |
| divisor | input | 16 | Rate divisor; 0 turns the port off |
| parMode | input | 3 | Parity selection (see R4) |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Transmit request |
| txReady | output | 1 | Transmitter idle and able to accept a byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | Unread byte present |
| rxRead | input | 1 | Consume the received byte |
| clrStatus | input | 1 | Clear all error flags |
| parityErr | output | 1 | Sticky parity error |
| frameErr | output | 1 | Sticky framing error |
| overrunErr | output | 1 | Sticky overrun error |

## Verification
Two receive events can fall in one cycle: the completion of a frame and a consumer read. To force this overlap, the bench holds `rxRead` high for the whole of an incoming frame and drops it at the first sample point where `rxValid` is seen high. The outcome is correct if the new byte is still flagged valid and no overrun is reported. A second case waits out two frames without any read between them. It then checks that only the overrun path fired and that the later byte replaced the earlier one.

// File: rtl/dbg_uart_pkg.sv
`timescale 1ns/1ps
package dbg_uart_pkg;

  localparam int DATA_BITS = 8;

  localparam logic [2:0] PAR_EVEN  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_SPACE = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;

  typedef enum logic [2:0] {
    LINE_IDLE,
    LINE_START,
    LINE_DATA,
    LINE_PAR,
    LINE_STOP
  } line_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  txLoad;
    logic  txShift;
    line_e txSel;
    logic  rxShift;
    logic  rxParTake;
    logic  rxFinish;
  } strobe_t;

  function automatic logic parityOn(input logic [2:0] mode);
    return mode < 3'd4;
  endfunction

  function automatic logic parityBit(input logic [DATA_BITS-1:0] d, input logic [2:0] mode);
    case (mode)
      PAR_EVEN:  return ^d;
      PAR_ODD:   return ~^d;
      PAR_SPACE: return 1'b0;
      PAR_MARK:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbg_uart_baud.sv
`timescale 1ns/1ps
module dbg_uart_baud #(
  parameter int CD_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CD_W-1:0] divisor,
  output logic            tick,
  output logic            enable
);

  logic [CD_W-1:0] divCnt;
  logic [CD_W-1:0] cdPrev;

  assign enable = divisor != '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      cdPrev <= '0;
      tick   <= 1'b0;
    end else begin
      cdPrev <= divisor;
      if (!enable || divisor != cdPrev) begin
        divCnt <= '0;
        tick   <= 1'b0;
      end else if (divCnt == divisor - CD_W'(1)) begin
        divCnt <= '0;
        tick   <= 1'b1;
      end else begin
        divCnt <= divCnt + CD_W'(1);
        tick   <= 1'b0;
      end
    end
  end

  AST_ZERO_CD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |=> !tick); // R2

  AST_RESTART_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (divisor != $past(divisor)) |=> !tick); // R10

endmodule

// File: rtl/dbg_uart_ctrl.sv
`timescale 1ns/1ps
module dbg_uart_ctrl
  import dbg_uart_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int NBITS = DATA_BITS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       enable,
  input  logic [2:0] parMode,
  input  logic       txValid,
  input  logic       rxBit,
  output logic       txReady,
  output strobe_t    strb
);

  localparam int TW = $clog2(OVS);
  localparam int IW = $clog2(NBITS);
  localparam logic [TW-1:0] TICK_LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] TICK_MID  = TW'(OVS / 2 - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(NBITS - 1);

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_e;

  phase_e          txPh, rxPh;
  logic [TW-1:0]   txTick, rxTick;
  logic [IW-1:0]   txIdx, rxIdx;
  logic            rxPrev;

  // transmitter sequencing
  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      txPh   <= PH_IDLE;
      txTick <= '0;
      txIdx  <= '0;
    end else if (txPh == PH_IDLE) begin
      if (txValid) begin
        txPh   <= PH_START;
        txTick <= '0;
      end
    end else if (tick) begin
      if (txTick == TICK_LAST) begin
        txTick <= '0;
        case (txPh)
          PH_START: begin
            txPh  <= PH_DATA;
            txIdx <= '0;
          end
          PH_DATA:
            if (txIdx == IDX_LAST) txPh <= parityOn(parMode) ? PH_PAR : PH_STOP;
            else                   txIdx <= txIdx + IW'(1);
          PH_PAR:  txPh <= PH_STOP;
          default: txPh <= PH_IDLE;
        endcase
      end else begin
        txTick <= txTick + TW'(1);
      end
    end
  end

  // receiver sequencing
  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      rxPh   <= PH_IDLE;
      rxTick <= '0;
      rxIdx  <= '0;
      rxPrev <= 1'b1;
    end else begin
      rxPrev <= rxBit;
      case (rxPh)
        PH_IDLE:
          if (rxPrev && !rxBit) begin
            rxPh   <= PH_START;
            rxTick <= '0;
          end
        PH_START:
          if (tick) begin
            if (rxTick == TICK_MID) begin
              rxTick <= '0;
              if (rxBit) rxPh <= PH_IDLE;
              else begin
                rxPh  <= PH_DATA;
                rxIdx <= '0;
              end
            end else begin
              rxTick <= rxTick + TW'(1);
            end
          end
        default:
          if (tick) begin
            if (rxTick == TICK_LAST) begin
              rxTick <= '0;
              case (rxPh)
                PH_DATA:
                  if (rxIdx == IDX_LAST) rxPh <= parityOn(parMode) ? PH_PAR : PH_STOP;
                  else                   rxIdx <= rxIdx + IW'(1);
                PH_PAR:  rxPh <= PH_STOP;
                default: rxPh <= PH_IDLE;
              endcase
            end else begin
              rxTick <= rxTick + TW'(1);
            end
          end
      endcase
    end
  end

  assign txReady = enable && txPh == PH_IDLE;

  always_comb begin
    strb           = '0;
    strb.txLoad    = txReady && txValid;
    strb.txShift   = txPh == PH_DATA && tick && txTick == TICK_LAST;
    case (txPh)
      PH_START: strb.txSel = LINE_START;
      PH_DATA:  strb.txSel = LINE_DATA;
      PH_PAR:   strb.txSel = LINE_PAR;
      PH_STOP:  strb.txSel = LINE_STOP;
      default:  strb.txSel = LINE_IDLE;
    endcase
    strb.rxShift   = rxPh == PH_DATA && tick && rxTick == TICK_LAST;
    strb.rxParTake = rxPh == PH_PAR  && tick && rxTick == TICK_LAST;
    strb.rxFinish  = rxPh == PH_STOP && tick && rxTick == TICK_LAST;
  end

  AST_OFF_PARKS_FSMS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txPh == PH_IDLE && rxPh == PH_IDLE)); // R2

  AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rxPh == PH_START && tick && rxTick == TICK_MID && rxBit) |=> rxPh == PH_IDLE); // R5

endmodule

// File: rtl/dbg_uart_dp.sv
`timescale 1ns/1ps
module dbg_uart_dp
  import dbg_uart_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [2:0]           parMode,
  input  logic [DATA_BITS-1:0] txData,
  output logic                 txd,
  input  logic                 rxd,
  output logic                 rxBit,
  input  logic                 rxRead,
  input  logic                 clrStatus,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 overrunErr
);

  logic                 rxMeta, rxSync;
  logic [DATA_BITS-1:0] txSh, rxSh;
  logic                 txParQ, rxParQ;

  assign rxBit = rxSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
    end
  end

  // transmit shifter and line register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh   <= '0;
      txParQ <= 1'b0;
      txd    <= 1'b1;
    end else begin
      if (strb.txLoad) begin
        txSh   <= txData;
        txParQ <= parityBit(txData, parMode);
      end else if (strb.txShift) begin
        txSh <= txSh >> 1;
      end
      case (strb.txSel)
        LINE_START: txd <= 1'b0;
        LINE_DATA:  txd <= txSh[0];
        LINE_PAR:   txd <= txParQ;
        default:    txd <= 1'b1;
      endcase
    end
  end

  // receive shifter, holding register and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh       <= '0;
      rxParQ     <= 1'b0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (strb.rxShift)   rxSh   <= {rxSync, rxSh[DATA_BITS-1:1]};
      if (strb.rxParTake) rxParQ <= rxSync;
      if (strb.rxFinish) begin
        rxData  <= rxSh;
        rxValid <= 1'b1;
      end else if (rxRead) begin
        rxValid <= 1'b0;
      end
      parityErr  <= (parityErr && !clrStatus) ||
                    (strb.rxFinish && parityOn(parMode) && rxParQ != parityBit(rxSh, parMode));
      frameErr   <= (frameErr && !clrStatus) || (strb.rxFinish && !rxSync);
      overrunErr <= (overrunErr && !clrStatus) || (strb.rxFinish && rxValid && !rxRead);
    end
  end

  AST_START_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txSel == LINE_START) |=> !txd); // R3

  AST_FINISH_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxFinish |=> rxValid); // R6

  AST_LOW_STOP_FRAMES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxFinish && !rxSync) |=> frameErr); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxFinish && rxValid && !rxRead) |=> overrunErr); // R9

endmodule

// File: rtl/dbg_uart.sv
`timescale 1ns/1ps
module dbg_uart
  import dbg_uart_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] divisor,
  input  logic [2:0]  parMode,
  input  logic [7:0]  txData,
  input  logic        txValid,
  output logic        txReady,
  output logic        txd,
  input  logic        rxd,
  output logic [7:0]  rxData,
  output logic        rxValid,
  input  logic        rxRead,
  input  logic        clrStatus,
  output logic        parityErr,
  output logic        frameErr,
  output logic        overrunErr
);

  logic    tick, enable, rxBit;
  strobe_t strb;

  dbg_uart_baud #(.CD_W(16)) i_baud (
    .clk(clk), .rstN(rstN), .divisor(divisor), .tick(tick), .enable(enable)
  );

  dbg_uart_ctrl #(.OVS(16), .NBITS(DATA_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .parMode(parMode),
    .txValid(txValid), .rxBit(rxBit), .txReady(txReady), .strb(strb)
  );

  dbg_uart_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .parMode(parMode), .txData(txData),
    .txd(txd), .rxd(rxd), .rxBit(rxBit), .rxRead(rxRead), .clrStatus(clrStatus),
    .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr)
  );

endmodule

// File: tb/test_dbg_uart.sv
`timescale 1ns/1ps
module test_dbg_uart;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] divisor;
  logic [2:0]  parMode;
  logic [7:0]  txData;
  logic        txValid, txReady, txd, rxd;
  logic [7:0]  rxData;
  logic        rxValid, rxRead, clrStatus;
  logic        parityErr, frameErr, overrunErr;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dbg_uart i_dbg_uart (
    .clk(clk), .rstN(rstN), .divisor(divisor), .parMode(parMode),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txd(txd), .rxd(rxd),
    .rxData(rxData), .rxValid(rxValid), .rxRead(rxRead), .clrStatus(clrStatus),
    .parityErr(parityErr), .frameErr(frameErr), .overrunErr(overrunErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic logic benchPar(input logic [7:0] d, input logic [2:0] m);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    case (m)
      3'd0: return (ones % 2) == 1;
      3'd1: return (ones % 2) == 0;
      3'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushTx(input logic [7:0] d);
    txData  = d;
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic grabTx(input int cd, input bit hasPar, output logic [7:0] d,
                        output logic p, output logic stopv);
    int guard = 0;
    d = '0;
    p = 1'b0;
    while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    wait_cycles(8 * cd);
    for (int i = 0; i < 8; i++) begin wait_cycles(16 * cd); d[i] = txd; end
    if (hasPar) begin wait_cycles(16 * cd); p = txd; end
    wait_cycles(16 * cd);
    stopv = txd;
  endtask

  task automatic driveRx(input int cd, input logic [7:0] d, input logic [2:0] m,
                         input bit flipPar, input logic stopVal);
    rxd = 1'b0;
    wait_cycles(16 * cd);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_cycles(16 * cd); end
    if (m < 3'd4) begin rxd = benchPar(d, m) ^ flipPar; wait_cycles(16 * cd); end
    rxd = stopVal;
    wait_cycles(16 * cd);
    rxd = 1'b1;
    wait_cycles(4 * cd);
  endtask

  task automatic pulseRead();
    rxRead = 1'b1; @(negedge clk); rxRead = 1'b0; @(negedge clk);
  endtask

  task automatic pulseClear();
    clrStatus = 1'b1; @(negedge clk); clrStatus = 1'b0; @(negedge clk);
  endtask

  task automatic tReset();
    chk("R3 txd idle high after reset", txd, 1);
    chk("R6 rxValid low after reset", rxValid, 0);
    chk("R7 flags clear after reset", {parityErr, frameErr, overrunErr}, 0);
    chk("R2 txReady with nonzero divisor", txReady, 1);
  endtask

  task automatic tTxModes();
    logic [7:0] d, got;
    logic p, s;
    for (int m = 0; m < 5; m++) begin
      parMode = 3'(m);
      d = 8'h5B ^ 8'(m << 2);
      pushTx(d);
      grabTx(1, m < 4, got, p, s);
      chk($sformatf("R3 tx data mode %0d", m), got, d);
      if (m < 4) chk($sformatf("R4 tx parity mode %0d", m), p, benchPar(d, 3'(m)));
      chk("R3 tx stop high", s, 1);
      wait_cycles(20);
      chk("R3 txd rests high", txd, 1);
    end
  endtask

  task automatic measureLow(input int cd);
    int cnt = 0;
    int guard = 0;
    pushTx(8'h00);
    while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    while (txd === 1'b0 && cnt < 20000) begin @(negedge clk); cnt++; end
    chkRange($sformatf("R1 R10 low run length at divisor %0d", cd), cnt, 144 * cd - cd, 144 * cd + 1);
    wait_cycles(20 * cd);
  endtask

  task automatic tRate();
    parMode = 3'd4;
    divisor = 16'd5;
    wait_cycles(7);
    divisor = 16'd3;     // counter may sit above the new limit: must restart
    wait_cycles(2);
    measureLow(3);
    divisor = 16'd1;
    wait_cycles(2);
    measureLow(1);
  endtask

  task automatic tZero();
    int lows = 0;
    divisor = 16'd0;
    wait_cycles(3);
    chk("R2 txReady low when off", txReady, 0);
    txData  = 8'h00;
    txValid = 1'b1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
    txValid = 1'b0;
    chk("R2 txd held high when off", lows, 0);
    driveRx(1, 8'h3C, 3'd4, 0, 1'b1);
    chk("R2 no reception when off", rxValid, 0);
    divisor = 16'd1;
    wait_cycles(4);
    chk("R2 txReady back after restore", txReady, 1);
    lows = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
    chk("R2 request while off not sent", lows, 0);
  endtask

  task automatic tRxGood();
    logic [7:0] d;
    for (int m = 0; m < 5; m++) begin
      parMode = 3'(m);
      d = 8'hC6 ^ 8'(m * 37);
      driveRx(1, d, 3'(m), 0, 1'b1);
      chk("R6 rxValid after frame", rxValid, 1);
      chk($sformatf("R6 rx data mode %0d", m), rxData, d);
      chk($sformatf("R4 R8 no parity error mode %0d", m), parityErr, 0);
      chk("R7 no framing error", frameErr, 0);
      chk("R9 no overrun", overrunErr, 0);
      pulseRead();
      chk("R6 read lowers rxValid", rxValid, 0);
    end
  endtask

  task automatic tRxErrors();
    parMode = 3'd1;
    driveRx(1, 8'h71, 3'd1, 1, 1'b1);
    chk("R8 odd parity mismatch flagged", parityErr, 1);
    pulseClear();
    chk("R7 clear empties parity flag", parityErr, 0);
    chk("R7 clear keeps rxValid", rxValid, 1);
    pulseRead();
    parMode = 3'd3;
    driveRx(1, 8'h0F, 3'd3, 1, 1'b1);
    chk("R4 mark parity mismatch flagged", parityErr, 1);
    pulseClear();
    pulseRead();
    parMode = 3'd4;
    driveRx(1, 8'hE2, 3'd4, 0, 1'b0);
    chk("R7 low stop sets frameErr", frameErr, 1);
    chk("R7 data still delivered", rxData, 8'hE2);
    chk("R8 no parity check when off", parityErr, 0);
    wait_cycles(10);
    chk("R7 frameErr sticky", frameErr, 1);
    pulseClear();
    chk("R7 clear empties frameErr", frameErr, 0);
    pulseRead();
  endtask

  task automatic tGlitch();
    parMode = 3'd4;
    divisor = 16'd2;
    wait_cycles(4);
    rxd = 1'b0;
    wait_cycles(4);
    rxd = 1'b1;
    wait_cycles(60);
    chk("R5 short low pulse dropped", rxValid, 0);
    driveRx(2, 8'hC3, 3'd4, 0, 1'b1);
    chk("R5 receiver usable after drop", rxValid, 1);
    chk("R5 data after drop", rxData, 8'hC3);
    pulseRead();
    divisor = 16'd1;
    wait_cycles(4);
  endtask

  task automatic tOverrun();
    parMode = 3'd0;
    driveRx(1, 8'hA1, 3'd0, 0, 1'b1);
    chk("R9 first byte no overrun", overrunErr, 0);
    driveRx(1, 8'h1A, 3'd0, 0, 1'b1);
    chk("R9 overrun flagged", overrunErr, 1);
    chk("R9 data overwritten", rxData, 8'h1A);
    pulseClear();
    chk("R9 overrun cleared", overrunErr, 0);
    chk("R7 clear leaves rxValid", rxValid, 1);
    pulseRead();
  endtask

  task automatic tCollide();
    parMode = 3'd4;
    rxRead  = 1'b1;
    fork
      driveRx(1, 8'h66, 3'd4, 0, 1'b1);
      begin
        int guard = 0;
        while (!rxValid && guard < 2000) begin @(negedge clk); guard++; end
        rxRead = 1'b0;
      end
    join
    chk("R6 completion beats simultaneous read", rxValid, 1);
    chk("R6 byte kept in collision", rxData, 8'h66);
    chk("R9 no overrun in collision", overrunErr, 0);
    pulseRead();
  endtask

  task automatic tDuplex();
    logic [7:0] got;
    logic p, s;
    parMode = 3'd0;
    fork
      begin pushTx(8'h96); grabTx(1, 1, got, p, s); end
      driveRx(1, 8'h4E, 3'd0, 0, 1'b1);
    join
    wait_cycles(20);
    chk("R11 tx data during reception", got, 8'h96);
    chk("R11 tx parity during reception", p, benchPar(8'h96, 3'd0));
    chk("R11 rx data during transmission", rxData, 8'h4E);
    chk("R11 rx clean during transmission", {parityErr, frameErr, overrunErr}, 0);
    pulseRead();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; divisor = 16'd1; parMode = 3'd4;
    txData = '0; txValid = 1'b0; rxd = 1'b1; rxRead = 1'b0; clrStatus = 1'b0;
    wait_cycles(5);
    rstN = 1'b1;
    wait_cycles(3);
    tReset();
    tTxModes();
    tRate();
    tZero();
    tRxGood();
    tRxErrors();
    tGlitch();
    tOverrun();
    tCollide();
    tDuplex();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule